// File: doc/BRIEF.md
# Programmable Parallel I/O Port

This block is a bus-attached parallel port with three 8-bit ports (A, B and C) and one control register. It occupies four byte offsets on a plain select/read/write strobe bus. A configuration word written to the control offset sets the direction of each port group. Port C is split into an upper nibble and a lower nibble, and each nibble has its own direction. Each pin has three signals: an output value, an output enable, and a sampled input. Output values always come from a per-port latch. The output enable is high only for bits configured as outputs.

Software uses the block in two ways. It configures directions once, which clears every output latch. After that it reads and writes ports directly. A read of an output port returns its latch, so a read-modify-write bit toggle works. A control word with bit 7 clear is not a configuration word: it sets or clears one bit of the port C latch. Group mode fields are decoded and stored, but the ports always behave in the basic unstrobed mode.

Top module: `pio_port_unit`

## Requirements
- R1: After reset, all output enables are 0, all output latches are 0, and a read of offset 3 returns 0x9B.
- R2: Offsets are 0 for port A, 1 for port B, 2 for port C and 3 for control. A write without `bus_sel` changes no state. `bus_rdata` is 0 unless `bus_sel` and `bus_rd` are both high.
- R3: A control word with bit 7 = 1 configures directions, where a 1 means input. Bit 4 sets port A, bit 1 sets port B, bit 3 sets port C bits 7:4 and bit 0 sets port C bits 3:0. The output enable of an input bit is 0 and of an output bit is 1, from the cycle after the write.
- R4: A configuration write clears the latches of all three ports to 0 in the same clock edge.
- R5: Bits 6:5 (port A group mode) and bit 2 (port B group mode) are stored and read back at offset 3, with bit 7 read as 1. They have no effect on port behaviour.
- R6: A write to offset 0, 1 or 2 loads that port's latch, whatever its direction. Each `*_out` bus always shows its latch.
- R7: A read of a port bit configured as output returns the latch bit.
- R8: A read of a port bit configured as input returns the pin, combinationally. For port C, each nibble follows its own direction.
- R9: A control word with bit 7 = 0 sets port C latch bit `wdata[3:1]` to `wdata[0]`. Bits 6:4 are ignored. The configuration and all other latch bits are unchanged.
- R10: The configuration word 0x8F makes port A an output and port B and both port C nibbles inputs. Toggling A bit 0 by read, XOR and write then flips `pa_out[0]` on each pass.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Block select |
| bus_wr | input | 1 | Write strobe, sampled on the clock edge |
| bus_rd | input | 1 | Read strobe, data returned combinationally |
| bus_addr | input | 2 | Offset within the four-byte window |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| pa_in | input | 8 | Port A pin samples |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A per-bit output enable |
| pb_in | input | 8 | Port B pin samples |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B per-bit output enable |
| pc_in | input | 8 | Port C pin samples |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C per-bit output enable |

## Verification
A wrong stored direction bit shows one cycle after the configuration write. It appears on the output enables, and in the same cycle a read of that port returns the latch where the pin was expected, or the reverse. A latch that fails to clear, or a set/reset command that reaches the wrong bit, shows on the `*_out` buses at the next clock edge. It does not wait for a later read. A fault that only affects mode bits or a half of port C shows only through a readback of offset 3 or a mixed-direction port C read. For this reason all 128 configuration words are swept, each followed by accesses to every port.

// File: rtl/pio_pkg.sv
package pio_pkg;

    parameter int unsigned PIO_W  = 8;
    localparam int unsigned IDX_W = $clog2(PIO_W);
    localparam int unsigned HALF  = PIO_W / 2;
    localparam int unsigned NLANE = 3;

    typedef enum logic [1:0] {
        OFS_A    = 2'd0,
        OFS_B    = 2'd1,
        OFS_C    = 2'd2,
        OFS_CTRL = 2'd3
    } ofs_e;

    // Field order follows control word bits 6..0.
    typedef struct packed {
        logic [1:0] grp_a_mode;
        logic       a_in;
        logic       cu_in;
        logic       grp_b_mode;
        logic       b_in;
        logic       cl_in;
    } cfg_t;

    typedef struct packed {
        logic             en;
        logic [IDX_W-1:0] idx;
        logic             val;
    } bitop_t;

    localparam cfg_t CFG_RESET = '{grp_a_mode: 2'b00, a_in: 1'b1, cu_in: 1'b1,
                                   grp_b_mode: 1'b0, b_in: 1'b1, cl_in: 1'b1};

    function automatic cfg_t cfg_from_word(input logic [7:0] w);
        return cfg_t'(w[6:0]);
    endfunction

    function automatic logic [7:0] cfg_to_word(input cfg_t c);
        return {1'b1, c};
    endfunction

    function automatic logic [PIO_W-1:0] lane_in_mask(input cfg_t c, input int unsigned lane);
        logic [PIO_W-1:0] m;
        case (lane)
            0:       m = {PIO_W{c.a_in}};
            1:       m = {PIO_W{c.b_in}};
            default: m = {{HALF{c.cu_in}}, {HALF{c.cl_in}}};
        endcase
        return m;
    endfunction

endpackage

// File: rtl/pio_ctrl_reg.sv
module pio_ctrl_reg
    import pio_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  logic        ctrl_wr,
    input  logic [7:0]  wdata,
    output cfg_t        cfg,
    output logic        clr_all,
    output bitop_t      bitop
);

    logic cfg_wr;

    assign cfg_wr   = ctrl_wr & wdata[7];
    assign clr_all  = cfg_wr;

    assign bitop.en  = ctrl_wr & ~wdata[7];
    assign bitop.idx = wdata[IDX_W:1];
    assign bitop.val = wdata[0];

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg <= CFG_RESET;
        end else if (cfg_wr) begin
            cfg <= cfg_from_word(wdata);
        end
    end

endmodule

// File: rtl/pio_port_lane.sv
module pio_port_lane #(
    parameter int unsigned W     = 8,
    parameter int unsigned IDX_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             ld,
    input  logic [W-1:0]     ld_data,
    input  logic             clr,
    input  logic             bitop_en,
    input  logic [IDX_W-1:0] bitop_idx,
    input  logic             bitop_val,
    input  logic [W-1:0]     in_mask,
    input  logic [W-1:0]     pins,
    output logic [W-1:0]     q,
    output logic [W-1:0]     oe,
    output logic [W-1:0]     rd_val
);

    localparam logic [W-1:0] ONE = {{(W-1){1'b0}}, 1'b1};

    logic [W-1:0] bop_mask;
    logic [W-1:0] q_next;

    assign bop_mask = bitop_en ? (ONE << bitop_idx) : '0;

    always_comb begin
        q_next = q;
        if (clr) begin
            q_next = '0;
        end else if (ld) begin
            q_next = ld_data;
        end else begin
            q_next = (q & ~bop_mask) | ({W{bitop_val}} & bop_mask);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            q <= '0;
        end else begin
            q <= q_next;
        end
    end

    assign oe     = ~in_mask;
    assign rd_val = (in_mask & pins) | (~in_mask & q);

endmodule

// File: rtl/pio_port_unit.sv
module pio_port_unit
    import pio_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic             bus_sel,
    input  logic             bus_wr,
    input  logic             bus_rd,
    input  logic [1:0]       bus_addr,
    input  logic [7:0]       bus_wdata,
    output logic [7:0]       bus_rdata,
    input  logic [PIO_W-1:0] pa_in,
    output logic [PIO_W-1:0] pa_out,
    output logic [PIO_W-1:0] pa_oe,
    input  logic [PIO_W-1:0] pb_in,
    output logic [PIO_W-1:0] pb_out,
    output logic [PIO_W-1:0] pb_oe,
    input  logic [PIO_W-1:0] pc_in,
    output logic [PIO_W-1:0] pc_out,
    output logic [PIO_W-1:0] pc_oe
);

    logic   acc_wr;
    logic   ctrl_wr;
    cfg_t   cfg;
    logic   clr_all;
    bitop_t bitop;

    logic [PIO_W-1:0] lane_pins [NLANE];
    logic [PIO_W-1:0] lane_q    [NLANE];
    logic [PIO_W-1:0] lane_oe   [NLANE];
    logic [PIO_W-1:0] lane_rd   [NLANE];

    assign acc_wr  = bus_sel & bus_wr;
    assign ctrl_wr = acc_wr & (ofs_e'(bus_addr) == OFS_CTRL);

    pio_ctrl_reg u_ctrl (
        .clk     (clk),
        .rst     (rst),
        .ctrl_wr (ctrl_wr),
        .wdata   (bus_wdata),
        .cfg     (cfg),
        .clr_all (clr_all),
        .bitop   (bitop)
    );

    assign lane_pins[0] = pa_in;
    assign lane_pins[1] = pb_in;
    assign lane_pins[2] = pc_in;

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        logic ld_g;
        logic bop_g;
        assign ld_g  = acc_wr & (bus_addr == 2'(g));
        assign bop_g = (g == 2) ? bitop.en : 1'b0;

        pio_port_lane #(
            .W     (PIO_W),
            .IDX_W (IDX_W)
        ) u_lane (
            .clk       (clk),
            .rst       (rst),
            .ld        (ld_g),
            .ld_data   (bus_wdata[PIO_W-1:0]),
            .clr       (clr_all),
            .bitop_en  (bop_g),
            .bitop_idx (bitop.idx),
            .bitop_val (bitop.val),
            .in_mask   (lane_in_mask(cfg, g)),
            .pins      (lane_pins[g]),
            .q         (lane_q[g]),
            .oe        (lane_oe[g]),
            .rd_val    (lane_rd[g])
        );
    end

    assign pa_out = lane_q[0];
    assign pb_out = lane_q[1];
    assign pc_out = lane_q[2];
    assign pa_oe  = lane_oe[0];
    assign pb_oe  = lane_oe[1];
    assign pc_oe  = lane_oe[2];

    always_comb begin
        bus_rdata = '0;
        if (bus_sel && bus_rd) begin
            case (ofs_e'(bus_addr))
                OFS_A:    bus_rdata = lane_rd[0];
                OFS_B:    bus_rdata = lane_rd[1];
                OFS_C:    bus_rdata = lane_rd[2];
                default:  bus_rdata = cfg_to_word(cfg);
            endcase
        end
    end

endmodule

// File: rtl/pio_port_unit_chk.sv
module pio_port_unit_chk (
    input  logic       clk,
    input  logic       rst,
    input  logic       bus_sel,
    input  logic       bus_wr,
    input  logic       bus_rd,
    input  logic [1:0] bus_addr,
    input  logic [7:0] bus_wdata,
    input  logic [7:0] bus_rdata,
    input  logic [7:0] pa_in,
    input  logic [7:0] pa_out,
    input  logic [7:0] pa_oe,
    input  logic [7:0] pb_in,
    input  logic [7:0] pb_out,
    input  logic [7:0] pb_oe,
    input  logic [7:0] pc_in,
    input  logic [7:0] pc_out,
    input  logic [7:0] pc_oe
);

    logic cfg_wr_c;
    logic bsr_wr_c;
    logic rd_a_c;

    assign cfg_wr_c = bus_sel && bus_wr && bus_addr == 2'd3 && bus_wdata[7];
    assign bsr_wr_c = bus_sel && bus_wr && bus_addr == 2'd3 && !bus_wdata[7];
    assign rd_a_c   = bus_sel && bus_rd && bus_addr == 2'd0;

    assert_reset_idle_R1: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (pa_oe == 8'h00 && pb_oe == 8'h00 && pc_oe == 8'h00 &&
                        pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    assert_unselected_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) && $stable(pa_oe)));

    assert_dir_applied_R3: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_c |=> (pa_oe == {8{~$past(bus_wdata[4])}} && pb_oe == {8{~$past(bus_wdata[1])}} &&
                      pc_oe == {{4{~$past(bus_wdata[3])}}, {4{~$past(bus_wdata[0])}}}));

    assert_cfg_clears_R4: assert property (@(posedge clk) disable iff (rst)
        cfg_wr_c |=> (pa_out == 8'h00 && pb_out == 8'h00 && pc_out == 8'h00));

    assert_out_read_R7: assert property (@(posedge clk) disable iff (rst)
        (rd_a_c && pa_oe == 8'hFF) |-> bus_rdata == pa_out);

    assert_in_read_R8: assert property (@(posedge clk) disable iff (rst)
        (rd_a_c && pa_oe == 8'h00) |-> bus_rdata == pa_in);

    assert_bitop_target_R9: assert property (@(posedge clk) disable iff (rst)
        bsr_wr_c |=> (pc_out[$past(bus_wdata[3:1])] == $past(bus_wdata[0]) &&
                      ((pc_out ^ $past(pc_out)) & ~(8'h01 << $past(bus_wdata[3:1]))) == 8'h00 &&
                      $stable(pa_out) && $stable(pb_out) && $stable(pc_oe)));

endmodule

bind pio_port_unit pio_port_unit_chk i_chk (.*);

// File: tb/test_pio_port_unit.sv
module test_pio_port_unit;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_sel = 1'b0, bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic [7:0] bus_wdata = 8'h00;
    logic [7:0] bus_rdata;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int unsigned n_vec = 0;
    int unsigned n_bad = 0;
    bit          done  = 1'b0;

    logic [7:0] m_cfg, m_a, m_b, m_c;

    always #4 clk = ~clk;

    pio_port_unit i_pio_port_unit (.*);

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        n_vec++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%02h expected=%02h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] exp_inmask(input int p);
        case (p)
            0:       return {8{m_cfg[4]}};
            1:       return {8{m_cfg[1]}};
            default: return {{4{m_cfg[3]}}, {4{m_cfg[0]}}};
        endcase
    endfunction

    function automatic logic [7:0] exp_read(input int p);
        logic [7:0] msk, lat, pin;
        msk = exp_inmask(p);
        lat = (p == 0) ? m_a : (p == 1) ? m_b : m_c;
        pin = (p == 0) ? pa_in : (p == 1) ? pb_in : pc_in;
        return (msk & pin) | (~msk & lat);
    endfunction

    task automatic wr(input logic [1:0] a, input logic [7:0] d, input bit sel = 1'b1);
        @(negedge clk);
        bus_sel = sel; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
        if (sel) begin
            if (a == 2'd3) begin
                if (d[7]) begin
                    m_cfg = d; m_a = 8'h00; m_b = 8'h00; m_c = 8'h00;
                end else begin
                    m_c[d[3:1]] = d[0];
                end
            end else if (a == 2'd0) m_a = d;
            else if (a == 2'd1) m_b = d;
            else m_c = d;
        end
        #1;
    endtask

    task automatic rd(input logic [1:0] a, output logic [7:0] d);
        bus_sel = 1'b1; bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0; bus_rd = 1'b0;
    endtask

    task automatic chk_pins(input string tag);
        chk({tag, " pa_out R6"}, pa_out, m_a);
        chk({tag, " pb_out R6"}, pb_out, m_b);
        chk({tag, " pc_out R6"}, pc_out, m_c);
        chk({tag, " pa_oe R3"}, pa_oe, ~exp_inmask(0));
        chk({tag, " pb_oe R3"}, pb_oe, ~exp_inmask(1));
        chk({tag, " pc_oe R3"}, pc_oe, ~exp_inmask(2));
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] r;
        m_cfg = 8'h9B; m_a = 8'h00; m_b = 8'h00; m_c = 8'h00;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk); #1;

        // R1: reset state
        chk_pins("R1 reset");
        rd(2'd3, r); chk("R1 ctrl readback", r, 8'h9B);
        pa_in = 8'h5A;
        rd(2'd0, r); chk("R8 input read after reset", r, 8'h5A);

        // R2: unselected accesses
        wr(2'd3, 8'h80, 1'b0);
        wr(2'd2, 8'hC3, 1'b0);
        chk_pins("R2 unselected write");
        rd(2'd3, r); chk("R2 ctrl unchanged", r, 8'h9B);
        bus_rd = 1'b1; bus_addr = 2'd3; #1;
        chk("R2 rdata zero without sel", bus_rdata, 8'h00);
        bus_rd = 1'b0;

        // R3 R4 R5 R6 R7 R8: every configuration word
        for (int d = 0; d < 128; d++) begin
            wr(2'd1, 8'hFF);
            wr(2'd3, 8'h80 | 8'(d));
            chk("R4 latches cleared A", pa_out, 8'h00);
            chk("R4 latches cleared C", pc_out, 8'h00);
            chk_pins("R3 cfg");
            rd(2'd3, r); chk("R5 ctrl readback", r, 8'h80 | 8'(d));
            wr(2'd0, 8'(d * 37 + 5));
            wr(2'd1, 8'(d * 11 + 99));
            wr(2'd2, 8'(d * 5 + 200));
            chk_pins("R6 after port writes");
            pa_in = 8'(d * 3 + 1); pb_in = 8'(~d); pc_in = 8'(d * 29 + 7);
            #1;
            for (int p = 0; p < 3; p++) begin
                rd(2'(p), r); chk("R7/R8 port read", r, exp_read(p));
            end
        end

        // R9: single-bit set/reset on port C
        wr(2'd3, 8'h80);
        wr(2'd0, 8'hA5);
        wr(2'd1, 8'h3C);
        wr(2'd2, 8'h00);
        for (int b = 0; b < 8; b++) begin
            wr(2'd3, 8'(((b * 3) & 7) << 4) | 8'(b << 1) | 8'h01);
            chk("R9 bit set", pc_out, m_c);
            chk("R9 A unchanged", pa_out, 8'hA5);
            chk("R9 B unchanged", pb_out, 8'h3C);
        end
        chk("R9 all set", pc_out, 8'hFF);
        for (int b = 7; b >= 0; b--) begin
            wr(2'd3, 8'h70 | 8'(b << 1));
            chk("R9 bit clear", pc_out, m_c);
        end
        chk("R9 all clear", pc_out, 8'h00);
        rd(2'd3, r); chk("R9 cfg unchanged", r, 8'h80);
        chk_pins("R9 oe unchanged");

        // R10: 0x8F and read-modify-write toggle of A bit 0
        wr(2'd3, 8'h8F);
        chk("R10 A output", pa_oe, 8'hFF);
        chk("R10 B input", pb_oe, 8'h00);
        chk("R10 C input", pc_oe, 8'h00);
        for (int t = 0; t < 4; t++) begin
            rd(2'd0, r);
            wr(2'd0, r ^ 8'h01);
            chk("R10 toggle", pa_out, (t % 2 == 0) ? 8'h01 : 8'h00);
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end

endmodule